// File: doc/BRIEF.md
# Bank Conflict Scoreboard

This block sits in front of a storage array that is split into several independently timed banks. Every cycle it looks at the requests presented to the array, works out which bank each set index lands in, and answers in the same cycle whether each access may start. A granted access occupies its bank for a fixed number of cycles. A request that targets an occupied bank is refused, and the requester is expected to retry in a later cycle.

Several request ports may be presented in one cycle. They are resolved in a fixed order, lowest port first, and each port sees the reservations made by the ports before it. A later port that asks for exactly the same index as the access that just reserved the bank in this cycle is accepted again. It rides on the reservation already made and does not extend it. A later port that asks for a different index in that bank is refused.

The bank count, index width, access latency and port count are parameters. An access latency of zero turns the block into a pass-through that accepts everything.

Top module: `bank_busy_board`

## Requirements
- R1: With an access latency of 0, every valid request is granted in its cycle, and no request ever causes a later request to be refused.
- R2: The target bank is the set index modulo the bank count, which is the low log2(bank count) bits of the index (bank count is a power of two).
- R3: With a single bank, every index maps to bank 0, so any two requests conflict regardless of their index values.
- R4: A grant in cycle t keeps its bank occupied in cycles t through t+LAT-1. A request to that bank in cycle t+LAT is granted.
- R5: A valid request to an occupied bank is refused, including a request for the same index in a later cycle of the window.
- R6: When a later port in the same cycle requests the same index in a bank that an earlier port freshly reserved in that cycle, it is granted and the occupancy window still ends at t+LAT-1.
- R7: Ports are resolved in order from port 0 upward. A later port asking for a different index in a bank reserved earlier in the same cycle is refused.
- R8: Reset returns all banks to idle, so the first request to any bank after reset is granted even if that bank was occupied when reset arrived.
- R9: A port whose valid is low is never granted and reserves nothing.
- R10: Reservations in one bank do not affect grants to other banks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_vld | input | NUM_PORTS | Per-port request valid |
| req_idx | input | NUM_PORTS*IDX_W | Per-port set index, port p in bits [p*IDX_W +: IDX_W] |
| req_grant | output | NUM_PORTS | Per-port grant, combinational from this cycle's requests and bank state |

## Verification
Two cases are the hardest to reach from the ports. The first is the same-cycle repeat, where two ports carry an identical index into a freshly reserved bank. The second is a request that lands exactly on the first free cycle after the window. Directed steps drive both ports with equal indices, then equal banks with different indices. They also hammer one bank on every cycle so that both the last occupied cycle and the first free cycle are sampled. The random phase draws indices from a range only four times the bank count, which keeps collisions and repeats frequent. The same stimulus also drives a zero-latency instance and a single-bank instance.

// File: rtl/bank_busy_pkg.sv
package bank_busy_pkg;

  // Bank selected by an index for a power-of-two bank count.
  function automatic int unsigned bank_sel(input logic [31:0] idx,
                                           input int unsigned nbanks);
    if (nbanks <= 1) return 0;
    return int'(idx & (nbanks - 1));
  endfunction

endpackage

// File: rtl/bank_map.sv
module bank_map #(
  parameter int NUM_BANKS = 4,
  parameter int IDX_W     = 8,
  parameter int BANK_W    = 2
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [BANK_W-1:0] bank
);

  generate
    if (NUM_BANKS == 1) begin : g_single
      assign bank = '0;
    end else begin : g_multi
      assign bank = idx[BANK_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/bank_timer.sv
module bank_timer #(
  parameter int ACC_LAT = 3,
  parameter int CNT_W   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);

  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(ACC_LAT - 1);

  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] rem_d;
  logic             rem_en;

  assign busy   = (rem_q != '0);
  assign rem_en = load | busy;

  always_comb begin
    rem_d = rem_q;
    if (load) begin
      rem_d = RELOAD;
    end else if (busy) begin
      rem_d = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (rem_en) begin
      rem_q <= rem_d;
    end
  end

endmodule

// File: rtl/port_stage.sv
module port_stage #(
  parameter int NUM_BANKS = 4,
  parameter int IDX_W     = 8,
  parameter int BANK_W    = 2,
  parameter int ACC_LAT   = 3
) (
  input  logic                       vld,
  input  logic [IDX_W-1:0]           idx,
  input  logic [BANK_W-1:0]          bank,
  input  logic [NUM_BANKS-1:0]       busy_in,
  input  logic [NUM_BANKS-1:0]       fresh_in,
  input  logic [NUM_BANKS*IDX_W-1:0] fidx_in,
  output logic                       grant,
  output logic [NUM_BANKS-1:0]       fresh_out,
  output logic [NUM_BANKS*IDX_W-1:0] fidx_out
);

  logic occupied;
  logic repeat_hit;

  always_comb begin
    fresh_out  = fresh_in;
    fidx_out   = fidx_in;
    grant      = 1'b0;
    occupied   = busy_in[bank] | fresh_in[bank];
    repeat_hit = fresh_in[bank] &&
                 (fidx_in[bank*IDX_W +: IDX_W] == idx);
    if (ACC_LAT == 0) begin
      grant = vld;
    end else if (vld) begin
      if (!occupied) begin
        grant                         = 1'b1;
        fresh_out[bank]               = 1'b1;
        fidx_out[bank*IDX_W +: IDX_W] = idx;
      end else if (repeat_hit) begin
        grant = 1'b1;
      end
    end
  end

endmodule

// File: rtl/bank_busy_board.sv
module bank_busy_board #(
  parameter int NUM_BANKS = 4,
  parameter int IDX_W     = 8,
  parameter int ACC_LAT   = 3,
  parameter int NUM_PORTS = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PORTS-1:0]       req_vld,
  input  logic [NUM_PORTS*IDX_W-1:0] req_idx,
  output logic [NUM_PORTS-1:0]       req_grant
);

  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int CNT_W  = (ACC_LAT > 2) ? $clog2(ACC_LAT) : 1;

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe[1];

  logic [NUM_BANKS-1:0]       timer_busy;
  logic [NUM_BANKS-1:0]       fresh_c [NUM_PORTS+1];
  logic [NUM_BANKS*IDX_W-1:0] fidx_c  [NUM_PORTS+1];
  logic [BANK_W-1:0]          bank_p  [NUM_PORTS];

  assign fresh_c[0] = '0;
  assign fidx_c[0]  = '0;

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      bank_map #(
        .NUM_BANKS (NUM_BANKS),
        .IDX_W     (IDX_W),
        .BANK_W    (BANK_W)
      ) u_map (
        .idx  (req_idx[p*IDX_W +: IDX_W]),
        .bank (bank_p[p])
      );

      port_stage #(
        .NUM_BANKS (NUM_BANKS),
        .IDX_W     (IDX_W),
        .BANK_W    (BANK_W),
        .ACC_LAT   (ACC_LAT)
      ) u_stage (
        .vld       (req_vld[p]),
        .idx       (req_idx[p*IDX_W +: IDX_W]),
        .bank      (bank_p[p]),
        .busy_in   (timer_busy),
        .fresh_in  (fresh_c[p]),
        .fidx_in   (fidx_c[p]),
        .grant     (req_grant[p]),
        .fresh_out (fresh_c[p+1]),
        .fidx_out  (fidx_c[p+1])
      );
    end

    if (ACC_LAT > 0) begin : g_timed
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_timer #(
          .ACC_LAT (ACC_LAT),
          .CNT_W   (CNT_W)
        ) u_timer (
          .clk   (clk),
          .rst_n (rst_sync_n),
          .load  (fresh_c[NUM_PORTS][b]),
          .busy  (timer_busy[b])
        );
      end
    end else begin : g_untimed
      assign timer_busy = '0;
    end
  endgenerate

endmodule

// File: rtl/bank_busy_board_chk.sv
module bank_busy_board_chk #(
  parameter int NUM_BANKS = 4,
  parameter int IDX_W     = 8,
  parameter int ACC_LAT   = 3,
  parameter int NUM_PORTS = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_PORTS-1:0]       req_vld,
  input logic [NUM_PORTS*IDX_W-1:0] req_idx,
  input logic [NUM_PORTS-1:0]       req_grant,
  input logic [NUM_BANKS-1:0]       busy_q
);
  import bank_busy_pkg::*;

  int unsigned bank0;
  int unsigned bank0_q;

  assign bank0 = bank_sel(32'(req_idx[IDX_W-1:0]), NUM_BANKS);

  always_ff @(posedge clk) bank0_q <= bank0;

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
      assert_idle_no_grant_R9: assert property (@(posedge clk)
        disable iff (!rst_n) !req_vld[p] |-> !req_grant[p]);
      if (ACC_LAT == 0) begin : g_z
        assert_zero_lat_grant_R1: assert property (@(posedge clk)
          disable iff (!rst_n) req_vld[p] |-> req_grant[p]);
      end
    end

    if (ACC_LAT > 0) begin : g_t
      assert_busy_refused_R5: assert property (@(posedge clk)
        disable iff (!rst_n) (req_vld[0] && busy_q[bank0]) |-> !req_grant[0]);
    end

    if (ACC_LAT > 1) begin : g_l
      assert_reserve_held_R4: assert property (@(posedge clk)
        disable iff (!rst_n) (req_vld[0] && req_grant[0]) |=> busy_q[bank0_q]);
    end

    if (NUM_PORTS > 1 && ACC_LAT > 0) begin : g_m
      assert_same_idx_repeat_R6: assert property (@(posedge clk)
        disable iff (!rst_n)
        (req_vld[0] && req_vld[1] && req_grant[0] &&
         req_idx[IDX_W-1:0] == req_idx[IDX_W +: IDX_W]) |-> req_grant[1]);
      assert_order_conflict_R7: assert property (@(posedge clk)
        disable iff (!rst_n)
        (req_vld[0] && req_vld[1] && req_grant[0] &&
         bank0 == bank_sel(32'(req_idx[IDX_W +: IDX_W]), NUM_BANKS) &&
         req_idx[IDX_W-1:0] != req_idx[IDX_W +: IDX_W]) |-> !req_grant[1]);
    end
  endgenerate

endmodule

bind bank_busy_board bank_busy_board_chk #(
  .NUM_BANKS (NUM_BANKS),
  .IDX_W     (IDX_W),
  .ACC_LAT   (ACC_LAT),
  .NUM_PORTS (NUM_PORTS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_vld   (req_vld),
  .req_idx   (req_idx),
  .req_grant (req_grant),
  .busy_q    (timer_busy)
);

// File: tb/bank_busy_board_test.sv
`timescale 1ns/1ps
module bank_busy_board_test;

  localparam int IDX_W = 8;
  localparam int NDUT  = 3;

  logic       clk;
  logic       rst_n;
  logic [1:0] req_vld;
  logic [2*IDX_W-1:0] req_idx;
  logic [1:0] g_main, g_zero, g_one;

  int checks;
  int errors;
  bit done;

  // Model state per instance: 0 = 4 banks lat 3, 1 = lat 0, 2 = 1 bank lat 2.
  int lat [NDUT] = '{3, 0, 2};
  int nb  [NDUT] = '{4, 4, 1};
  int rem [NDUT][4];

  bank_busy_board #(.NUM_BANKS(4), .IDX_W(IDX_W), .ACC_LAT(3), .NUM_PORTS(2)) uut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_idx(req_idx), .req_grant(g_main));
  bank_busy_board #(.NUM_BANKS(4), .IDX_W(IDX_W), .ACC_LAT(0), .NUM_PORTS(2)) uut_zero (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_idx(req_idx), .req_grant(g_zero));
  bank_busy_board #(.NUM_BANKS(1), .IDX_W(IDX_W), .ACC_LAT(2), .NUM_PORTS(2)) uut_one (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_idx(req_idx), .req_grant(g_one));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit actual(input int d, input int p);
    case (d)
      0: return g_main[p];
      1: return g_zero[p];
      default: return g_one[p];
    endcase
  endfunction

  task automatic clear_model();
    for (int d = 0; d < NDUT; d++)
      for (int b = 0; b < 4; b++) rem[d][b] = 0;
  endtask

  // One cycle: drive, predict, compare, advance the model past the next edge.
  task automatic step(input bit v0, input int i0, input bit v1, input int i1,
                      input string note);
    bit vv [2];
    int ii [2];
    vv[0] = v0; vv[1] = v1; ii[0] = i0; ii[1] = i1;
    @(negedge clk);
    req_vld = {v1, v0};
    req_idx = {IDX_W'(i1), IDX_W'(i0)};
    #2;
    for (int d = 0; d < NDUT; d++) begin
      bit fresh [4];
      int fidx  [4];
      for (int b = 0; b < 4; b++) begin fresh[b] = 0; fidx[b] = 0; end
      for (int p = 0; p < 2; p++) begin
        bit    exp_g;
        bit    act_g;
        string tag;
        int    b;
        b = (nb[d] == 1) ? 0 : (ii[p] % nb[d]);
        exp_g = 0;
        tag = "R2";
        if (!vv[p]) begin
          tag = "R9";
        end else if (lat[d] == 0) begin
          exp_g = 1; tag = "R1";
        end else if (rem[d][b] == 0 && !fresh[b]) begin
          exp_g = 1; fresh[b] = 1; fidx[b] = ii[p];
          tag = (d == 2) ? "R3" : "R4";
        end else if (fresh[b] && fidx[b] == ii[p]) begin
          exp_g = 1; tag = "R6";
        end else if (fresh[b]) begin
          tag = (d == 2) ? "R3" : "R7";
        end else begin
          tag = "R5";
        end
        act_g = actual(d, p);
        checks++;
        if (act_g !== exp_g) begin
          errors++;
          $display("FAIL %s (%s) inst%0d port%0d idx=%0d: actual=%0b expected=%0b",
                   tag, note, d, p, ii[p], act_g, exp_g);
        end
      end
      for (int b = 0; b < 4; b++) begin
        if (fresh[b]) rem[d][b] = lat[d] - 1;
        else if (rem[d][b] > 0) rem[d][b]--;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    req_vld = '0;
    rst_n   = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    clear_model();
    repeat (3) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, "R9 idle");
  endtask

  initial begin
    checks  = 0;
    errors  = 0;
    done    = 0;
    req_vld = '0;
    req_idx = '0;
    rst_n   = 1'b0;
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: first request after reset to each bank granted.
    step(1, 16, 1, 1, "R8 first after reset");
    idle(3);
    // R6: same index on both ports in the same cycle.
    step(1, 5, 1, 5, "R6 repeat");
    // R5/R4: hammer bank 1 through the window and past its end.
    step(1, 5, 0, 0, "R5 same idx later cycle");
    step(1, 9, 0, 0, "R5 other idx");
    step(1, 13, 0, 0, "R4 first free cycle");
    idle(3);
    // R7: same bank, different index.
    step(1, 6, 1, 10, "R7 ordered conflict");
    idle(3);
    // R10 / R2: distinct banks, high index bits ignored for mapping.
    step(1, 8'h40, 1, 8'h83, "R10 R2 distinct banks");
    step(1, 8'hC1, 1, 8'h02, "R10 R2 other banks");
    idle(3);
    // R9: invalid port 0 leaves the bank free for port 1.
    step(0, 7, 1, 7, "R9 invalid reserves nothing");
    idle(3);
    // R8: reset while occupied.
    step(1, 3, 0, 0, "R8 occupy before reset");
    do_reset();
    step(1, 3, 1, 7, "R8 free after reset");
    idle(3);

    // Random phase with fixed seed.
    void'($urandom(32'd20240611));
    for (int n = 0; n < 3000; n++) begin
      bit v0, v1;
      int i0, i1;
      v0 = ($urandom % 10) < 6;
      v1 = ($urandom % 10) < 6;
      i0 = $urandom % 16;
      i1 = (($urandom % 4) == 0) ? i0 : ($urandom % 16);
      step(v0, i0, v1, i1, "random R2 R4 R5 R6 R7 R10");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule